// File: doc/BRIEF.md
# Elastic Buffer with Idle-Based Rate Correction

This block is a dual-clock receive buffer. Words arrive every cycle of a recovered write clock and leave every cycle of a local read clock. The two clocks are asynchronous and differ slightly in frequency. The block keeps the buffer's fill level inside a programmable band by acting only on idle words in the stream. When the write side finds the buffer too full, it drops an incoming idle. When the read side finds it too empty, it sends out the idle it just delivered a second time.

Each domain computes its own occupancy. It uses its local binary pointer and the other domain's pointer, which crosses as Gray code through two flip-flops. The read side stays silent after reset until the buffer holds at least the low threshold. After each correction, that domain waits a fixed number of cycles before it may correct again, so that the changed pointer can reach the other side. Correction runs only while the enable input is high and the drop-sequence input is low. If the thresholds cannot hold the level inside the buffer, a sticky overflow or underflow flag is raised.

Top module: `ebuf_idle_corr`

## Requirements
- R1: While its reset is high, each side clears its pointers and flags: `rd_vld`, `ovf_flag` and `unf_flag` are 0.
- R2: After reset the read side outputs nothing (`rd_vld`=0) until its occupancy is nonzero and at least `lat_lo`. From then on, with correction active, every non-idle word appears on `rd_data` once, in write order, with none missing.
- R3: When correction is active, the write-side occupancy is above `lat_hi`, the incoming word equals the idle code (0xBC by default) and the write side is not holding off, that word is not stored.
- R4: When correction is active, the read side is running, the read-side occupancy is below `lat_lo`, the last delivered word was a valid idle and the read side is not holding off, the same idle is delivered again and the read pointer stays put.
- R5: After a correction, the domain that made it makes no further correction for HOLD cycles (default 4). With idles spaced apart in the input, no more than two consecutive valid idles appear at the output.
- R6: Correction is active only when `corr_en`=1 and `seq_drop`=0. Otherwise no idle is dropped or repeated.
- R7: When the write-side occupancy equals the buffer depth (default 16) and a word is to be stored, the word is discarded and `ovf_flag` rises and stays high until write reset.
- R8: When the read side is running, its occupancy is zero and no insertion applies, `rd_vld` is 0 for that cycle and `unf_flag` rises and stays high until read reset.
- R9: At an empty read side, an idle repetition (R4) takes precedence over the underflow response, so it does not raise `unf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_data | input | DATA_W | Word written on each write clock |
| rd_clk | input | 1 | Local read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_data | output | DATA_W | Delivered word |
| rd_vld | output | 1 | `rd_data` is valid this cycle |
| corr_en | input | 1 | Correction enable (quasi-static) |
| seq_drop | input | 1 | Drop-sequence mode; disables correction when high (quasi-static) |
| lat_lo | input | ADDR_W+1 | Low occupancy threshold, used in the read domain |
| lat_hi | input | ADDR_W+1 | High occupancy threshold, used in the write domain |
| ovf_flag | output | 1 | Sticky overflow, write domain |
| unf_flag | output | 1 | Sticky underflow, read domain |

## Verification
Idle repetition and the empty condition can fall in the same read cycle, because the insertion test runs exactly when occupancy is low. A slow write clock against the read clock drives the read side down to its low threshold again and again. A correct ordering then gives a growing count of repeated idles, `unf_flag` stays low, and runs of consecutive idles are never longer than two. With correction disabled under the same slow clock, the same starvation must instead raise `unf_flag`, which shows which rule decided each case.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;

    localparam int unsigned EB_DATA_W = 8;
    localparam int unsigned EB_ADDR_W = 4;
    localparam logic [7:0]  EB_IDLE   = 8'hBC;
    localparam int unsigned EB_HOLD   = 4;

    typedef enum logic {
        RS_FILL = 1'b0,
        RS_RUN  = 1'b1
    } rd_state_e;

    function automatic logic eb_active(input logic corr_en, input logic seq_drop);
        return corr_en & ~seq_drop;
    endfunction

endpackage

// File: rtl/ebuf_sync.sv
module ebuf_sync #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ebuf_wr_side.sv
module ebuf_wr_side
    import ebuf_pkg::*;
#(
    parameter int unsigned         DATA_W = EB_DATA_W,
    parameter int unsigned         ADDR_W = EB_ADDR_W,
    parameter logic [DATA_W-1:0]   IDLE   = DATA_W'(EB_IDLE),
    parameter int unsigned         HOLD   = EB_HOLD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [ADDR_W:0]   lat_hi,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W:0]   rd_gray_s,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wr_gray,
    output logic              ovf
);
    localparam int unsigned PW    = ADDR_W + 1;
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned HW    = $clog2(HOLD + 1);

    logic [PW-1:0] wr_bin, rbin_s, occ, nxt;
    logic [HW-1:0] hold;
    logic          full, rm_fire, lost;

    always_comb begin
        rbin_s[PW-1] = rd_gray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rbin_s[i] = rbin_s[i+1] ^ rd_gray_s[i];
        end
    end

    assign occ     = wr_bin - rbin_s;
    assign full    = (occ == PW'(DEPTH));
    assign rm_fire = active && (occ > lat_hi) && (din == IDLE) && (hold == '0);
    assign we      = !rm_fire && !full;
    assign lost    = !rm_fire && full;
    assign nxt     = wr_bin + PW'(1);
    assign waddr   = wr_bin[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
            hold    <= '0;
            ovf     <= 1'b0;
        end else begin
            if (we) begin
                wr_bin  <= nxt;
                wr_gray <= nxt ^ (nxt >> 1);
            end
            if (rm_fire)
                hold <= HW'(HOLD);
            else if (hold != '0)
                hold <= hold - HW'(1);
            if (lost)
                ovf <= 1'b1;
        end
    end

    AST_REMOVE_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        rm_fire |=> (wr_bin == $past(wr_bin))); // R3
    AST_WR_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        rm_fire |=> !rm_fire); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf); // R7
    AST_WR_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(wr_gray ^ $past(wr_gray)) <= 1)); // R2
    AST_NO_OVERFLOW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        full |=> (wr_bin == $past(wr_bin))); // R7
endmodule

// File: rtl/ebuf_rd_side.sv
module ebuf_rd_side
    import ebuf_pkg::*;
#(
    parameter int unsigned         DATA_W = EB_DATA_W,
    parameter int unsigned         ADDR_W = EB_ADDR_W,
    parameter logic [DATA_W-1:0]   IDLE   = DATA_W'(EB_IDLE),
    parameter int unsigned         HOLD   = EB_HOLD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [ADDR_W:0]   lat_lo,
    input  logic [ADDR_W:0]   wr_gray_s,
    input  logic [DATA_W-1:0] mem_word,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rd_gray,
    output logic [DATA_W-1:0] dout,
    output logic              vld,
    output logic              unf
);
    localparam int unsigned PW = ADDR_W + 1;
    localparam int unsigned HW = $clog2(HOLD + 1);

    logic [PW-1:0] rd_bin, wbin_s, occ, nxt;
    logic [HW-1:0] hold;
    rd_state_e     st;
    logic          start, ins_fire, take, starve;

    always_comb begin
        wbin_s[PW-1] = wr_gray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin_s[i] = wbin_s[i+1] ^ wr_gray_s[i];
        end
    end

    assign occ      = wbin_s - rd_bin;
    assign start    = (st == RS_FILL) && (occ >= lat_lo) && (occ != '0);
    // Insertion is evaluated ahead of the empty test (R9)
    assign ins_fire = active && (st == RS_RUN) && vld && (dout == IDLE)
                      && (occ < lat_lo) && (hold == '0);
    assign take     = ((st == RS_RUN) || start) && !ins_fire && (occ != '0);
    assign starve   = (st == RS_RUN) && !ins_fire && (occ == '0);
    assign nxt      = rd_bin + PW'(1);
    assign raddr    = rd_bin[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin  <= '0;
            rd_gray <= '0;
            hold    <= '0;
            st      <= RS_FILL;
            dout    <= '0;
            vld     <= 1'b0;
            unf     <= 1'b0;
        end else begin
            if (start)
                st <= RS_RUN;
            if (take) begin
                dout    <= mem_word;
                vld     <= 1'b1;
                rd_bin  <= nxt;
                rd_gray <= nxt ^ (nxt >> 1);
            end else if (ins_fire) begin
                vld <= 1'b1;
            end else begin
                vld <= 1'b0;
            end
            if (ins_fire)
                hold <= HW'(HOLD);
            else if (hold != '0)
                hold <= hold - HW'(1);
            if (starve)
                unf <= 1'b1;
        end
    end

    AST_INSERT_REPEATS: assert property (@(posedge clk) disable iff (rst)
        ins_fire |=> (vld && dout == $past(dout) && rd_bin == $past(rd_bin))); // R4
    AST_RD_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        ins_fire |=> !ins_fire); // R5
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
        unf |=> unf); // R8
    AST_FILL_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st == RS_FILL && !start) |=> !vld); // R2
    AST_INSERT_NO_UNF: assert property (@(posedge clk) disable iff (rst)
        (ins_fire && !unf) |=> !unf); // R9
endmodule

// File: rtl/ebuf_idle_corr.sv
module ebuf_idle_corr
    import ebuf_pkg::*;
#(
    parameter int unsigned         DATA_W = EB_DATA_W,
    parameter int unsigned         ADDR_W = EB_ADDR_W,
    parameter logic [DATA_W-1:0]   IDLE   = DATA_W'(EB_IDLE),
    parameter int unsigned         HOLD   = EB_HOLD
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    input  logic              corr_en,
    input  logic              seq_drop,
    input  logic [ADDR_W:0]   lat_lo,
    input  logic [ADDR_W:0]   lat_hi,
    output logic              ovf_flag,
    output logic              unf_flag
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned PW    = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_we;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [PW-1:0]     wr_gray, rd_gray, wr_gray_s, rd_gray_s;
    logic              active;

    assign active = eb_active(corr_en, seq_drop);

    always_ff @(posedge wr_clk) begin
        if (wr_we)
            mem[wr_addr] <= wr_data;
    end

    ebuf_sync #(.W(PW)) u_sync_r2w (
        .clk (wr_clk), .rst (wr_rst), .d (rd_gray), .q (rd_gray_s)
    );

    ebuf_sync #(.W(PW)) u_sync_w2r (
        .clk (rd_clk), .rst (rd_rst), .d (wr_gray), .q (wr_gray_s)
    );

    ebuf_wr_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDLE(IDLE), .HOLD(HOLD)) u_wr (
        .clk       (wr_clk),
        .rst       (wr_rst),
        .active    (active),
        .lat_hi    (lat_hi),
        .din       (wr_data),
        .rd_gray_s (rd_gray_s),
        .we        (wr_we),
        .waddr     (wr_addr),
        .wr_gray   (wr_gray),
        .ovf       (ovf_flag)
    );

    ebuf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDLE(IDLE), .HOLD(HOLD)) u_rd (
        .clk       (rd_clk),
        .rst       (rd_rst),
        .active    (active),
        .lat_lo    (lat_lo),
        .wr_gray_s (wr_gray_s),
        .mem_word  (mem[rd_addr]),
        .raddr     (rd_addr),
        .rd_gray   (rd_gray),
        .dout      (rd_data),
        .vld       (rd_vld),
        .unf       (unf_flag)
    );

    AST_RESET_QUIET: assert property (@(posedge rd_clk)
        $past(rd_rst) |-> (!rd_vld && !unf_flag)); // R1
endmodule

// File: tb/ebuf_idle_corr_tb.sv
`timescale 1ns/1ps
module ebuf_idle_corr_tb;
    localparam int unsigned DW = 8;
    localparam int unsigned AW = 4;
    localparam logic [DW-1:0] IDLE_W = 8'hBC;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst = 1'b1, rd_rst = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_vld, ovf_flag, unf_flag;
    logic          corr_en = 1'b1, seq_drop = 1'b0;
    logic [AW:0]   lat_lo = 5'd5, lat_hi = 5'd10;

    real    wr_half = 2.0;
    bit     wr_req = 1'b1, rd_req = 1'b1, done = 1'b0;
    int     checks = 0, errors = 0;
    int     snd_k = 0, sent_idle = 0;
    int     exp_d = 0, rcv_idle = 0, rcv_data = 0, run = 0, max_run = 0, ord_err = 0;

    ebuf_idle_corr #(.DATA_W(DW), .ADDR_W(AW), .IDLE(IDLE_W), .HOLD(4)) u_dut (
        .wr_clk (wr_clk), .wr_rst (wr_rst), .wr_data (wr_data),
        .rd_clk (rd_clk), .rd_rst (rd_rst), .rd_data (rd_data), .rd_vld (rd_vld),
        .corr_en (corr_en), .seq_drop (seq_drop), .lat_lo (lat_lo), .lat_hi (lat_hi),
        .ovf_flag (ovf_flag), .unf_flag (unf_flag)
    );

    initial forever #2.0 rd_clk = ~rd_clk;
    initial forever #(wr_half) wr_clk = ~wr_clk;

    function automatic logic [DW-1:0] word_at(input int k);
        if (k % 4 == 3) return IDLE_W;
        return DW'((k - k / 4) % 128);
    endfunction

    // write stimulus: a word is consumed at each posedge outside reset
    initial forever begin
        @(negedge wr_clk);
        if (!wr_rst) begin
            if (wr_data == IDLE_W) sent_idle++;
            snd_k++;
        end
        wr_rst = wr_req;
        if (wr_rst) begin
            snd_k = 0;
            sent_idle = 0;
        end
        wr_data = word_at(snd_k);
    end

    // read monitor
    initial forever begin
        @(negedge rd_clk);
        rd_rst = rd_req;
        if (rd_rst) begin
            exp_d = 0; rcv_idle = 0; rcv_data = 0; run = 0; max_run = 0; ord_err = 0;
        end else if (rd_vld) begin
            if (rd_data == IDLE_W) begin
                rcv_idle++;
                run++;
                if (run > max_run) max_run = run;
            end else begin
                run = 0;
                if (rd_data != DW'(exp_d % 128)) ord_err++;
                exp_d++;
                rcv_data++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wait_rd(input int n);
        repeat (n) @(posedge rd_clk);
        #0.5;
    endtask

    task automatic restart(input real half, input bit en, input bit sd,
                           input int lo, input int hi);
        wr_req = 1'b1;
        rd_req = 1'b1;
        wait_rd(8);
        wr_half  = half;
        corr_en  = en;
        seq_drop = sd;
        lat_lo   = 5'(lo);
        lat_hi   = 5'(hi);
        wait_rd(8);
        chk(rd_vld == 1'b0,   "R1 rd_vld in reset",   int'(rd_vld),   0);
        chk(ovf_flag == 1'b0, "R1 ovf_flag in reset", int'(ovf_flag), 0);
        chk(unf_flag == 1'b0, "R1 unf_flag in reset", int'(unf_flag), 0);
        wr_req = 1'b0;
        rd_req = 1'b0;
    endtask

    initial begin
        // Phase A: write clock faster, correction on -> idles removed (R3)
        restart(1.9, 1'b1, 1'b0, 5, 10);
        wait_rd(4000);
        chk(ord_err == 0,  "R2 order fast write", ord_err, 0);
        chk(rcv_data > 2000, "R2 data delivered fast write", rcv_data, 2001);
        chk(rcv_idle + 20 < sent_idle, "R3 idles removed", rcv_idle, sent_idle);
        chk(ovf_flag == 1'b0, "R3 no overflow with removal", int'(ovf_flag), 0);
        chk(unf_flag == 1'b0, "R8 no underflow fast write", int'(unf_flag), 0);

        // Phase B: write clock slower -> idles repeated (R4, R5, R9)
        restart(2.1, 1'b1, 1'b0, 5, 10);
        wait_rd(4000);
        chk(ord_err == 0,  "R2 order slow write", ord_err, 0);
        chk(rcv_data > 2000, "R2 data delivered slow write", rcv_data, 2001);
        chk(rcv_idle > sent_idle + 20, "R4 idles inserted", rcv_idle, sent_idle);
        chk(max_run <= 2, "R5 idle run bounded by hold", max_run, 2);
        chk(unf_flag == 1'b0, "R9 insertion beats underflow", int'(unf_flag), 0);
        chk(ovf_flag == 1'b0, "R7 no overflow slow write", int'(ovf_flag), 0);

        // Phase C: fast write, correction disabled -> overflow (R6, R7)
        restart(1.9, 1'b0, 1'b0, 5, 10);
        wait_rd(4000);
        chk(ovf_flag == 1'b1, "R6 R7 overflow when disabled", int'(ovf_flag), 1);
        chk(max_run <= 1, "R6 no idle repeated when disabled", max_run, 1);
        chk(unf_flag == 1'b0, "R8 no underflow when writes faster", int'(unf_flag), 0);

        // Phase D: slow write, drop-sequence high -> underflow (R6, R8)
        restart(2.1, 1'b1, 1'b1, 5, 10);
        wait_rd(4000);
        chk(unf_flag == 1'b1, "R6 R8 underflow with seq_drop", int'(unf_flag), 1);
        chk(max_run <= 1, "R6 no idle repeated with seq_drop", max_run, 1);
        chk(ovf_flag == 1'b0, "R7 no overflow slow write", int'(ovf_flag), 0);

        // Phase E: equal clocks, high low-threshold -> delayed start (R2)
        restart(2.0, 1'b1, 1'b0, 12, 14);
        wait_rd(8);
        chk(rd_vld == 1'b0, "R2 silent before lat_lo reached", int'(rd_vld), 0);
        wait_rd(60);
        chk(rd_vld == 1'b1, "R2 reading after lat_lo reached", int'(rd_vld), 1);
        wait_rd(2000);
        chk(ord_err == 0, "R2 order equal clocks", ord_err, 0);
        chk(ovf_flag == 1'b0 && unf_flag == 1'b0, "R7 R8 flags quiet equal clocks",
            int'(ovf_flag) + int'(unf_flag), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000.0;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule